// File: doc/BRIEF.md
# First-Error Bus Capture Unit

This block sits beside a bus bridge and records what went wrong on the first failed bus transaction after power comes up. An error detector elsewhere pulses `err_valid` for one cycle and presents the failing transaction's address, bus command and transfer type with it. The unit stores these fields. When it is in host-bridge mode it also stores the number of the bus master that owned the bus.

Once a record is taken, the unit locks. It keeps that record until the next power-on reset, whatever errors follow. Software-level resets do not disturb it. A registered read port with a 2-bit select returns the stored fields, and a flag output tells interrupt logic that a record is held.

Top module: `err_first_capture`

## Requirements
- R1: The first `err_valid` pulse after power-on reset stores `err_addr` and sets the held flag. Reading select 0 then returns the stored address.
- R2: The same pulse stores `err_cmd` and `err_type`. Select 1 returns a word with the command in bits [3:0], the type in bits [5:4] and zeros above.
- R3: The master number is stored only if `host_mode` is 1 in the capture cycle. Select 2 returns it in bits [2:0] with zeros above. If the capture happens with `host_mode` at 0, the master register keeps its reset value of zero.
- R4: Any `err_valid` pulse after the first leaves every stored field unchanged, including a pulse in the very next cycle.
- R5: While `por_n` is low at a clock edge (synchronous, active low), all stored fields and the held flag clear to zero. Every select then reads zero, including select 2 in host mode.
- R6: `soft_rst_n` low never changes the stored fields or the held flag. It only clears the read data register to zero.
- R7: `rd_data` shows the value chosen by `rd_sel` one clock after `rd_sel` is presented. Select 3 returns the held flag in bit 0 with zeros above.
- R8: `err_flag` equals the held flag. It rises in the cycle after the first capture and stays high until power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low, clears the read register only |
| err_valid | input | 1 | One-cycle error event pulse |
| err_addr | input | 32 | Address of the failing transaction |
| err_cmd | input | 4 | Bus command of the failing transaction |
| err_type | input | 2 | Transfer type of the failing transaction |
| err_master_id | input | 3 | Bus master active during the failure |
| host_mode | input | 1 | 1 when operating as host bridge |
| rd_sel | input | 2 | Read select: 0 address, 1 command/type, 2 master, 3 flag |
| rd_data | output | 32 | Registered read data |
| err_flag | output | 1 | A record is held |

## Verification
Two functions can act in the same cycle: the lock that blocks a second capture, and a new error pulse arriving in the cycle right after the first. The bench provokes this by holding `err_valid` high for two consecutive edges with different field values. It then reads all four selects and expects only the first pulse's values. In a similar way, a soft reset is applied while a record is held and a read is pending. The bench judges this by checking that `rd_data` reads zero and that the next reads still return the held record.

// File: rtl/efc_pkg.sv
// Package: shared widths and read-select encoding for the first-error capture unit.
// Assumes the read word is at least as wide as the address field.
package efc_pkg;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam int TYPE_W = 2;
    localparam int MID_W  = 3;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_ADDR   = 2'd0,
        SEL_CMD    = 2'd1,
        SEL_MASTER = 2'd2,
        SEL_FLAG   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] xtype;
        logic [CMD_W-1:0]  cmd;
        logic [MID_W-1:0]  master;
        logic              held;
    } err_rec_t;
endpackage

// File: rtl/efc_capture.sv
// Module: efc_capture
// Holds the first error record taken after power-on reset and locks against later errors.
// Assumes err_valid is a single-cycle pulse. por_n is a synchronous active-low reset and is
// the only thing that clears the record.
module efc_capture
    import efc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CMD_W,
    parameter int TW = TYPE_W,
    parameter int MW = MID_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          err_valid,
    input  logic [AW-1:0] err_addr,
    input  logic [CW-1:0] err_cmd,
    input  logic [TW-1:0] err_type,
    input  logic [MW-1:0] err_master_id,
    input  logic          host_mode,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cmd_q,
    output logic [TW-1:0] type_q,
    output logic [MW-1:0] master_q,
    output logic          held_q
);
    logic take;

    // Purpose: a capture happens only while nothing is held yet.
    always_comb take = err_valid && !held_q;

    // Purpose: store address, command and type on the first error; cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            type_q <= '0;
        end else if (take) begin
            addr_q <= err_addr;
            cmd_q  <= err_cmd;
            type_q <= err_type;
        end
    end

    // Purpose: store the master number only when capturing in host-bridge mode.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            master_q <= '0;
        end else if (take && host_mode) begin
            master_q <= err_master_id;
        end
    end

    // Purpose: sticky held flag, set by the capture and cleared by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            held_q <= 1'b0;
        end else if (take) begin
            held_q <= 1'b1;
        end
    end

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!por_n)
        (err_valid && !held_q) |=> (held_q && addr_q == $past(err_addr))); // R1
    AST_FIRST_CMD: assert property (@(posedge clk) disable iff (!por_n)
        (err_valid && !held_q) |=> (cmd_q == $past(err_cmd) && type_q == $past(err_type))); // R2
    AST_MASTER_NONHOST: assert property (@(posedge clk) disable iff (!por_n)
        (!host_mode) |=> $stable(master_q)); // R3
    AST_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
        held_q |=> ($stable(addr_q) && $stable(cmd_q) && $stable(type_q) && $stable(master_q))); // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        held_q |=> held_q); // R8
    AST_POR_CLEAR: assert property (@(posedge clk)
        (!por_n) |=> (!held_q && addr_q == '0 && master_q == '0)); // R5
endmodule

// File: rtl/efc_readout.sv
// Module: efc_readout
// Registered read mux over the held record. It gives one-cycle latency and zero-extends each field.
// Assumes DW is at least the address width. soft_rst_n and por_n both clear only this register.
module efc_readout
    import efc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CMD_W,
    parameter int TW = TYPE_W,
    parameter int MW = MID_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          soft_rst_n,
    input  logic [1:0]    rd_sel,
    input  logic [AW-1:0] addr_q,
    input  logic [CW-1:0] cmd_q,
    input  logic [TW-1:0] type_q,
    input  logic [MW-1:0] master_q,
    input  logic          held_q,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] rd_nx;

    // Purpose: choose and zero-extend the selected field.
    always_comb begin
        rd_nx = '0;
        case (rd_sel_e'(rd_sel))
            SEL_ADDR:   rd_nx[AW-1:0]     = addr_q;
            SEL_CMD:    rd_nx[CW+TW-1:0]  = {type_q, cmd_q};
            SEL_MASTER: rd_nx[MW-1:0]     = master_q;
            default:    rd_nx[0]          = held_q;
        endcase
    end

    // Purpose: register the read word; either reset clears only this register.
    always_ff @(posedge clk) begin
        if (!por_n || !soft_rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_nx;
        end
    end

    AST_SOFT_ZERO: assert property (@(posedge clk)
        (!soft_rst_n) |=> (rd_data == '0)); // R6
    AST_FLAG_READ: assert property (@(posedge clk) disable iff (!por_n || !soft_rst_n)
        (rd_sel == 2'd3) |=> (rd_data[0] == $past(held_q) && rd_data[DW-1:1] == '0)); // R7
endmodule

// File: rtl/err_first_capture.sv
// Module: err_first_capture (top)
// Records the first bus error after power-on reset and exposes it through a registered read port.
// Assumes one-cycle error pulses from an external detector.
module err_first_capture
    import efc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic              err_valid,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [CMD_W-1:0]  err_cmd,
    input  logic [TYPE_W-1:0] err_type,
    input  logic [MID_W-1:0]  err_master_id,
    input  logic              host_mode,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_flag
);
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [TYPE_W-1:0] type_q;
    logic [MID_W-1:0]  master_q;
    logic              held_q;

    efc_capture #(.AW(ADDR_W), .CW(CMD_W), .TW(TYPE_W), .MW(MID_W)) u_cap (
        .clk(clk), .por_n(por_n), .err_valid(err_valid), .err_addr(err_addr),
        .err_cmd(err_cmd), .err_type(err_type), .err_master_id(err_master_id),
        .host_mode(host_mode), .addr_q(addr_q), .cmd_q(cmd_q), .type_q(type_q),
        .master_q(master_q), .held_q(held_q)
    );

    efc_readout #(.AW(ADDR_W), .CW(CMD_W), .TW(TYPE_W), .MW(MID_W), .DW(DATA_W)) u_rd (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .rd_sel(rd_sel),
        .addr_q(addr_q), .cmd_q(cmd_q), .type_q(type_q), .master_q(master_q),
        .held_q(held_q), .rd_data(rd_data)
    );

    // Purpose: the status flag follows the held state.
    always_comb err_flag = held_q;
endmodule

// File: tb/sim_err_first_capture.sv
module sim_err_first_capture;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        err_valid = 1'b0;
    logic [31:0] err_addr = '0;
    logic [3:0]  err_cmd = '0;
    logic [1:0]  err_type = '0;
    logic [2:0]  err_master_id = '0;
    logic        host_mode = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        err_flag;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    err_first_capture u0 (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .err_valid(err_valid),
        .err_addr(err_addr), .err_cmd(err_cmd), .err_type(err_type),
        .err_master_id(err_master_id), .host_mode(host_mode), .rd_sel(rd_sel),
        .rd_data(rd_data), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic por();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk); rd_sel = s;
        @(posedge clk);
        @(negedge clk); v = rd_data;
    endtask

    task automatic err(input logic [31:0] a, input logic [3:0] c, input logic [1:0] t,
                       input logic [2:0] m, input logic h);
        @(negedge clk);
        err_valid = 1'b1; err_addr = a; err_cmd = c; err_type = t;
        err_master_id = m; host_mode = h;
        @(negedge clk); err_valid = 1'b0;
    endtask

    task automatic expect_rec(input string tag, input logic [31:0] a, input logic [3:0] c,
                              input logic [1:0] t, input logic [2:0] m, input logic f);
        logic [31:0] v;
        rd(2'd0, v); chk({tag, " R1 addr"}, v, a);
        rd(2'd1, v); chk({tag, " R2 cmd/type"}, v, {26'd0, t, c});
        rd(2'd2, v); chk({tag, " R3 master"}, v, {29'd0, m});
        rd(2'd3, v); chk({tag, " R7 flag"}, v, {31'd0, f});
        chk({tag, " R8 err_flag"}, {31'd0, err_flag}, {31'd0, f});
    endtask

    initial begin
        logic [31:0] v;
        por();
        // R5: reset state, host mode on, master reads zero
        host_mode = 1'b1;
        expect_rec("reset R5", 32'd0, 4'd0, 2'd0, 3'd0, 1'b0);

        // Sweep: every command, type and mode. R1 R2 R3 R4 R8
        for (int i = 0; i < 128; i++) begin
            logic [3:0] c; logic [1:0] t; logic h; logic [2:0] m; logic [31:0] a;
            c = i[3:0]; t = i[5:4]; h = i[6]; m = i[2:0] ^ 3'd5;
            a = 32'hA500_3C00 ^ (i * 32'h0101_0107);
            por();
            err(a, c, t, m, h);
            chk("R8 flag rises", {31'd0, err_flag}, 32'd1);
            expect_rec("sweep R1", a, c, t, h ? m : 3'd0, 1'b1);
            // R4: later error with different values ignored
            err(~a, ~c, ~t, ~m, 1'b1);
            expect_rec("later R4", a, c, t, h ? m : 3'd0, 1'b1);
        end

        // R4: back-to-back pulses, only the first kept
        por();
        @(negedge clk);
        err_valid = 1'b1; err_addr = 32'h1111_2222; err_cmd = 4'h6; err_type = 2'd1;
        err_master_id = 3'd2; host_mode = 1'b1;
        @(negedge clk);
        err_addr = 32'hDEAD_BEEF; err_cmd = 4'h9; err_type = 2'd2; err_master_id = 3'd7;
        @(negedge clk); err_valid = 1'b0;
        expect_rec("b2b R4", 32'h1111_2222, 4'h6, 2'd1, 3'd2, 1'b1);

        // R6: soft reset clears read register only
        @(negedge clk); rd_sel = 2'd0; soft_rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); chk("R6 rd_data zero", rd_data, 32'd0);
        chk("R6 flag kept", {31'd0, err_flag}, 32'd1);
        soft_rst_n = 1'b1;
        expect_rec("soft R6", 32'h1111_2222, 4'h6, 2'd1, 3'd2, 1'b1);

        // R5: power-on reset clears record
        por();
        expect_rec("por R5", 32'd0, 4'd0, 2'd0, 3'd0, 1'b0);

        // R7: one-cycle latency
        err(32'h0000_00F0, 4'h3, 2'd3, 3'd4, 1'b1);
        @(negedge clk); rd_sel = 2'd3;
        @(posedge clk);
        @(negedge clk); rd_sel = 2'd0;
        chk("R7 latency flag", rd_data, 32'd1);
        @(posedge clk);
        @(negedge clk); chk("R7 latency addr", rd_data, 32'h0000_00F0);
        rd(2'd1, v); chk("R2 final", v, {26'd0, 2'd3, 4'h3});
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule